// File: doc/BRIEF.md
# Flow-controlled asynchronous serial transceiver

This block is a full-duplex asynchronous serial port. Each character is one start bit, eight data bits sent least significant bit first, no parity bit, and one or two stop bits. A divisor input sets the bit rate. A one-clock tick is generated every `baud_div + 1` clocks, and one bit time is sixteen ticks. The transmitter takes bytes through a valid/ready pair. The receiver filters short glitches from the line, samples each bit at 16x oversampling, and places good characters in an eight-entry first-word-fall-through queue.

Transmission can be gated in two ways. In hardware handshake mode, a clear-to-send input holds back new characters and a ready-to-receive output is dropped as the receive queue fills. In software handshake mode, the pause and resume control characters that arrive on the receive line stop and restart the transmitter, and these characters are removed from the data stream.

A block mode limits the transmitter to a preloaded number of characters and inserts a programmable idle gap after each one. When the last character of the block has finished, a done interrupt is raised. A receive interrupt reports that the queue holds data.

Top module: `serial_link_uart`

## Requirements
- R1: The line idles high. A frame is a low start bit, data bits 0..7 in that order, no parity, then high stop bits. A transmitted byte looped back to the receiver is read out unchanged.
- R2: One bit lasts 16*(baud_div+1) clocks. Back-to-back frames start 10 bit times apart when stop2=0 and 11 bit times apart when stop2=1.
- R3: With block_mode=1 and gap_bits=G>0, consecutive frames start (10 or 11 + G) bit times apart.
- R4: A block_start pulse loads block_len into a remaining-character counter and clears the done flag. In block mode a character is accepted only while the counter is nonzero. After the final stop bit of the last character the done flag sets, and done_irq = done_irq_en & flag.
- R5: The receiver begins a character only if the filtered line is still low 8 ticks after the falling edge. It then samples each later bit 16 ticks apart, near mid-bit.
- R6: A change of the receive level is accepted only after 3 identical consecutive tick samples, so a pulse shorter than 3 ticks has no effect.
- R7: If a stop bit is sampled low, the character is discarded and frame_err pulses for one clock. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: The receive queue holds 8 bytes in arrival order, shows the oldest byte on rx_data, and counts its entries on rx_count. A character that arrives while the queue is full is dropped.
- R9: flow_sel=1 selects hardware handshake. In this mode no new character starts while cts_in is low, and rts_out is low when rx_count >= 6. In every other mode rts_out is high.
- R10: flow_sel=2 selects software handshake. A received 0x13 stops new characters from starting, a received 0x11 lets them start again, and neither byte enters the queue. In modes 0, 1 and 3 these bytes are stored as ordinary data.
- R11: rx_irq is high exactly when rx_irq_en is high and the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Tick divisor, one tick every baud_div+1 clocks |
| stop2 | input | 1 | 1 selects two transmit stop bits |
| flow_sel | input | 2 | 0 none, 1 hardware, 2 software, 3 none |
| block_mode | input | 1 | Enables block counting and the gap between characters |
| gap_bits | input | 8 | Idle bit times inserted after each character in block mode |
| block_len | input | 8 | Number of characters in a block |
| block_start | input | 1 | Loads the block counter and clears the done flag |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Byte taken on this clock |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| cts_in | input | 1 | High permits new characters (hardware mode) |
| rts_out | output | 1 | High while the receiver can take more data |
| rx_pop | input | 1 | Removes the oldest queued byte |
| rx_data | output | 8 | Oldest queued byte |
| rx_empty | output | 1 | Queue empty |
| rx_count | output | 4 | Queue occupancy |
| frame_err | output | 1 | One-clock pulse on a low stop bit |
| rx_irq_en | input | 1 | Receive interrupt mask |
| done_irq_en | input | 1 | Block-done interrupt mask |
| rx_irq | output | 1 | Receive interrupt |
| done_irq | output | 1 | Block-done interrupt |

## Verification
The bench loops all 256 byte values through the link and measures the spacing of frame start edges for both stop-bit settings, with a nonzero divisor and with a block gap. A wrong bit counter or a stop count reversed by one shows up there as a spacing error. It fires two-clock spikes into the idle line and into a data bit, and a filter that is too short would start a false character or flip a bit. It sends a frame with a low stop bit, which a receiver that does not wait for a high line would turn into an extra 0xFF. It also holds the transmitter with clear-to-send and with a pause byte, fills the queue past eight, and offers a character beyond the block length. A design that leaks the control bytes into the queue, overwrites stored data, or sends past the block would fail these checks.

// File: rtl/sl_pkg.sv
package sl_pkg;

  localparam logic [1:0] FLOW_NONE = 2'd0;
  localparam logic [1:0] FLOW_HW   = 2'd1;
  localparam logic [1:0] FLOW_SW   = 2'd2;

  localparam logic [7:0] CHAR_RESUME = 8'h11;
  localparam logic [7:0] CHAR_PAUSE  = 8'h13;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_GAP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
  } rx_state_e;

  // index of the final stop bit within the stop phase
  function automatic logic [2:0] last_stop_idx(input logic two_stop);
    return two_stop ? 3'd1 : 3'd0;
  endfunction

  function automatic logic is_flow_char(input logic [7:0] b);
    return (b == CHAR_RESUME) || (b == CHAR_PAUSE);
  endfunction

endpackage

// File: rtl/sl_glitch_filter.sv
module sl_glitch_filter #(
  parameter int FILT_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic [1:0]        sync_q;
  logic [FILT_N-1:0] hist_q;
  logic [FILT_N-1:0] hist_nxt;

  assign hist_nxt = {hist_q[FILT_N-2:0], sync_q[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      if (tick) begin
        hist_q <= hist_nxt;
        if (&hist_nxt)       dout <= 1'b1;
        else if (~|hist_nxt) dout <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sl_uart_tx.sv
module sl_uart_tx
  import sl_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stop2,
  input  logic             block_mode,
  input  logic [GAP_W-1:0] gap_bits,
  input  logic             may_send,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             txd,
  output logic             frame_end,
  output logic             busy
);
  tx_state_e        st;
  logic [3:0]       tcnt;
  logic [2:0]       bitn;
  logic [GAP_W-1:0] gapn;
  logic [7:0]       shreg;
  logic             bit_end, gap_needed, gap_last, load_slot;

  assign bit_end    = tick && (tcnt == 4'd15);
  assign gap_needed = block_mode && (gap_bits != '0);
  assign frame_end  = (st == TX_STOP) && bit_end && (bitn == last_stop_idx(stop2));
  assign gap_last   = (st == TX_GAP) && bit_end && (gapn == gap_bits - GAP_W'(1));
  // a new frame may begin from idle or seamlessly after the previous one
  assign load_slot  = (st == TX_IDLE) || (frame_end && !gap_needed) || gap_last;
  assign tx_ready   = load_slot && tx_valid && may_send;
  assign busy       = (st != TX_IDLE);
  assign txd        = (st == TX_START) ? 1'b0 :
                      (st == TX_DATA)  ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TX_IDLE;
      tcnt  <= '0;
      bitn  <= '0;
      gapn  <= '0;
      shreg <= '1;
    end else if (tx_ready) begin
      st    <= TX_START;
      tcnt  <= '0;
      bitn  <= '0;
      shreg <= tx_data;
    end else begin
      if (tick && st != TX_IDLE) tcnt <= tcnt + 4'd1;
      case (st)
        TX_START: if (bit_end) begin
          st   <= TX_DATA;
          bitn <= '0;
        end
        TX_DATA: if (bit_end) begin
          shreg <= {1'b1, shreg[7:1]};
          if (bitn == 3'd7) begin
            st   <= TX_STOP;
            bitn <= '0;
          end else begin
            bitn <= bitn + 3'd1;
          end
        end
        TX_STOP: if (bit_end) begin
          if (frame_end) begin
            if (gap_needed) begin
              st   <= TX_GAP;
              gapn <= '0;
            end else begin
              st <= TX_IDLE;
            end
          end else begin
            bitn <= bitn + 3'd1;
          end
        end
        TX_GAP: if (bit_end) begin
          if (gap_last) st <= TX_IDLE;
          else          gapn <= gapn + GAP_W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sl_uart_rx.sv
module sl_uart_rx
  import sl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxf,
  output logic       char_valid,
  output logic [7:0] char_data,
  output logic       frame_err
);
  rx_state_e  st;
  logic [3:0] tcnt;
  logic [2:0] bitn;
  logic [7:0] shreg;

  assign char_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      tcnt       <= '0;
      bitn       <= '0;
      shreg      <= '0;
      char_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      frame_err  <= 1'b0;
      case (st)
        RX_IDLE: if (tick && !rxf) begin
          st   <= RX_START;
          tcnt <= '0;
        end
        RX_START: if (tick) begin
          if (rxf) begin
            st <= RX_IDLE;
          end else if (tcnt == 4'd7) begin
            st   <= RX_DATA;
            tcnt <= '0;
            bitn <= '0;
          end else begin
            tcnt <= tcnt + 4'd1;
          end
        end
        RX_DATA: if (tick) begin
          if (tcnt == 4'd15) begin
            shreg <= {rxf, shreg[7:1]};
            tcnt  <= '0;
            if (bitn == 3'd7) st <= RX_STOP;
            else              bitn <= bitn + 3'd1;
          end else begin
            tcnt <= tcnt + 4'd1;
          end
        end
        RX_STOP: if (tick) begin
          if (tcnt == 4'd15) begin
            tcnt <= '0;
            if (rxf) begin
              char_valid <= 1'b1;
              st         <= RX_IDLE;
            end else begin
              frame_err <= 1'b1;
              st        <= RX_WAIT_HIGH;
            end
          end else begin
            tcnt <= tcnt + 4'd1;
          end
        end
        RX_WAIT_HIGH: if (rxf) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sl_rx_fifo.sv
module sl_rx_fifo #(
  parameter  int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             pop,
  output logic [7:0]       dout,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/serial_link_uart.sv
module serial_link_uart
  import sl_pkg::*;
#(
  parameter  int DIV_W      = 16,
  parameter  int GAP_W      = 8,
  parameter  int BLK_W      = 8,
  parameter  int FIFO_DEPTH = 8,
  parameter  int NEAR_FULL  = FIFO_DEPTH - 2,
  parameter  int FILT_N     = 3,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             stop2,
  input  logic [1:0]       flow_sel,
  input  logic             block_mode,
  input  logic [GAP_W-1:0] gap_bits,
  input  logic [BLK_W-1:0] block_len,
  input  logic             block_start,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  input  logic             cts_in,
  output logic             rts_out,
  input  logic             rx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_empty,
  output logic [CNT_W-1:0] rx_count,
  output logic             frame_err,
  input  logic             rx_irq_en,
  input  logic             done_irq_en,
  output logic             rx_irq,
  output logic             done_irq
);
  // named internal events, observed by the bound checker
  logic             tick;
  logic             tx_start, frame_end, tx_busy, may_send;
  logic             rxf, char_valid, fifo_push, fifo_full, paused, done_flag;
  logic [7:0]       char_data;
  logic [DIV_W-1:0] div_cnt;
  logic [BLK_W-1:0] blk_left;

  assign tick = (div_cnt == baud_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + DIV_W'(1);
  end

  assign may_send = !((flow_sel == FLOW_HW) && !cts_in)
                 && !((flow_sel == FLOW_SW) && paused)
                 && (!block_mode || (blk_left != '0));

  sl_uart_tx #(.GAP_W(GAP_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .stop2      (stop2),
    .block_mode (block_mode),
    .gap_bits   (gap_bits),
    .may_send   (may_send),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .txd        (txd),
    .frame_end  (frame_end),
    .busy       (tx_busy)
  );
  assign tx_start = tx_ready;

  // block character counter and completion flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_left  <= '0;
      done_flag <= 1'b0;
    end else if (block_start) begin
      blk_left  <= block_len;
      done_flag <= 1'b0;
    end else begin
      if (tx_start && block_mode && blk_left != '0) blk_left <= blk_left - BLK_W'(1);
      if (frame_end && block_mode && blk_left == '0) done_flag <= 1'b1;
    end
  end

  sl_glitch_filter #(.FILT_N(FILT_N)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .din   (rxd),
    .dout  (rxf)
  );

  sl_uart_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .rxf        (rxf),
    .char_valid (char_valid),
    .char_data  (char_data),
    .frame_err  (frame_err)
  );

  // software handshake: control bytes steer the pause state and are consumed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        paused <= 1'b0;
    else if (flow_sel != FLOW_SW)                      paused <= 1'b0;
    else if (char_valid && char_data == CHAR_PAUSE)    paused <= 1'b1;
    else if (char_valid && char_data == CHAR_RESUME)   paused <= 1'b0;
  end

  assign fifo_push = char_valid && !((flow_sel == FLOW_SW) && is_flow_char(char_data));

  sl_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   (char_data),
    .pop   (rx_pop),
    .dout  (rx_data),
    .empty (rx_empty),
    .full  (fifo_full),
    .count (rx_count)
  );

  assign rts_out  = (flow_sel == FLOW_HW) ? (rx_count < CNT_W'(NEAR_FULL)) : 1'b1;
  assign rx_irq   = rx_irq_en && !rx_empty;
  assign done_irq = done_irq_en && done_flag;
endmodule

// File: rtl/sl_uart_chk.sv
module sl_uart_chk #(
  parameter int BLK_W = 8,
  parameter int CNT_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_start,
  input logic             tx_busy,
  input logic             txd,
  input logic [1:0]       flow_sel,
  input logic             cts_in,
  input logic             paused,
  input logic             char_valid,
  input logic [7:0]       char_data,
  input logic             fifo_push,
  input logic [CNT_W-1:0] rx_count,
  input logic             block_mode,
  input logic [BLK_W-1:0] blk_left,
  input logic             done_flag
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R9
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !(flow_sel == 2'd1 && !cts_in));

  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && flow_sel == 2'd2) |-> !paused);

  // R10
  flow_char_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && flow_sel == 2'd2 && (char_data == 8'h11 || char_data == 8'h13)) |-> !fifo_push);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(DEPTH));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != $past(rx_count)) |-> (rx_count == $past(rx_count) + CNT_W'(1) || rx_count == $past(rx_count) - CNT_W'(1)));

  // R4
  block_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && block_mode) |-> blk_left != '0);

  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> (blk_left == '0));
endmodule

bind serial_link_uart sl_uart_chk #(
  .BLK_W (BLK_W),
  .CNT_W (CNT_W),
  .DEPTH (FIFO_DEPTH)
) u_sl_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_start   (tx_start),
  .tx_busy    (tx_busy),
  .txd        (txd),
  .flow_sel   (flow_sel),
  .cts_in     (cts_in),
  .paused     (paused),
  .char_valid (char_valid),
  .char_data  (char_data),
  .fifo_push  (fifo_push),
  .rx_count   (rx_count),
  .block_mode (block_mode),
  .blk_left   (blk_left),
  .done_flag  (done_flag)
);

// File: tb/tb_serial_link_uart.sv
module tb_serial_link_uart;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] baud_div;
  logic        stop2;
  logic [1:0]  flow_sel;
  logic        block_mode;
  logic [7:0]  gap_bits, block_len;
  logic        block_start;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready, txd, rxd, cts_in, rts_out, rx_pop;
  logic [7:0]  rx_data;
  logic        rx_empty;
  logic [3:0]  rx_count;
  logic        frame_err, rx_irq_en, done_irq_en, rx_irq, done_irq;
  logic        loop_en, drv_rxd;

  int n_tests = 0;
  int n_fail  = 0;
  int bit_cyc = 16;

  // monitors: these counters only ever grow
  int cyc = 0;
  int edge_n = 0;
  int fe_n = 0;
  int edge_cyc [64];
  logic txd_prev = 1'b1;

  always #5 clk = ~clk;

  assign rxd = loop_en ? txd : drv_rxd;

  serial_link_uart dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .stop2(stop2),
    .flow_sel(flow_sel), .block_mode(block_mode), .gap_bits(gap_bits),
    .block_len(block_len), .block_start(block_start), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
    .cts_in(cts_in), .rts_out(rts_out), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_empty(rx_empty), .rx_count(rx_count), .frame_err(frame_err),
    .rx_irq_en(rx_irq_en), .done_irq_en(done_irq_en), .rx_irq(rx_irq),
    .done_irq(done_irq)
  );

  always @(posedge clk) begin
    if (txd_prev && !txd) begin
      edge_cyc[edge_n % 64] = cyc;
      edge_n = edge_n + 1;
    end
    if (frame_err) fe_n = fe_n + 1;
    txd_prev = txd;
    cyc = cyc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    bit_cyc = 16 * (int'(baud_div) + 1);
    wait_cyc(2);
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    #1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // hold a byte on offer until a start edge appears, then withdraw it
  task automatic release_pending(input int base);
    int k = 0;
    while (edge_n == base && k < 4000) begin
      @(negedge clk);
      k++;
    end
    tx_valid = 1'b0;
  endtask

  task automatic wait_count(input int n);
    int k = 0;
    while (int'(rx_count) < n && k < 4000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic pop_one();
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic drive_rx(input logic [7:0] d, input bit good_stop, input int glitch_bit);
    drv_rxd = 1'b0;
    wait_cyc(bit_cyc);
    for (int i = 0; i < 8; i++) begin
      drv_rxd = d[i];
      if (i == glitch_bit) begin
        wait_cyc(bit_cyc / 2);
        drv_rxd = ~d[i];
        wait_cyc(2);
        drv_rxd = d[i];
        wait_cyc(bit_cyc / 2 - 2);
      end else begin
        wait_cyc(bit_cyc);
      end
    end
    drv_rxd = good_stop;
    wait_cyc(bit_cyc);
    drv_rxd = 1'b1;
    wait_cyc(bit_cyc);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int e0, f0;
    rst_n = 1'b0; baud_div = 16'd0; stop2 = 1'b0; flow_sel = 2'd0;
    block_mode = 1'b0; gap_bits = 8'd0; block_len = 8'd0; block_start = 1'b0;
    tx_valid = 1'b0; tx_data = 8'd0; cts_in = 1'b1; rx_pop = 1'b0;
    rx_irq_en = 1'b0; done_irq_en = 1'b0; loop_en = 1'b1; drv_rxd = 1'b1;
    do_reset();

    // reset state
    chk("R1 idle line", int'(txd), 1);
    chk("R8 empty at reset", int'(rx_empty), 1);
    chk("R8 count at reset", int'(rx_count), 0);
    chk("R9 rts at reset", int'(rts_out), 1);
    chk("R11 rx_irq at reset", int'(rx_irq), 0);
    chk("R4 done_irq at reset", int'(done_irq), 0);

    // R1 loopback sweep of every byte value; R10 control bytes stored in mode 0
    for (int b = 0; b < 256; b++) begin
      send_byte(8'(b));
      wait_count(1);
      if (b == 8'h11 || b == 8'h13) chk("R10 control byte kept in mode 0", int'(rx_data), b);
      else                          chk("R1 loopback byte", int'(rx_data), b);
      pop_one();
    end

    // R2 frame spacing, one stop bit, divisor 0
    do_reset();
    e0 = edge_n;
    repeat (3) send_byte(8'hFF);
    wait_cyc(200);
    chk("R2 spacing 1 stop", edge_cyc[(e0+1)%64] - edge_cyc[e0%64], 10 * 16);
    chk("R2 spacing 1 stop", edge_cyc[(e0+2)%64] - edge_cyc[(e0+1)%64], 10 * 16);

    // R2 two stop bits, divisor 2
    stop2 = 1'b1; baud_div = 16'd2;
    do_reset();
    e0 = edge_n;
    repeat (3) send_byte(8'hFF);
    wait_cyc(600);
    chk("R2 spacing 2 stop div 2", edge_cyc[(e0+2)%64] - edge_cyc[(e0+1)%64], 11 * 16 * 3);
    stop2 = 1'b0; baud_div = 16'd0;

    // R3 / R4 block mode with gap
    block_mode = 1'b1; gap_bits = 8'd3; block_len = 8'd3; done_irq_en = 1'b1;
    do_reset();
    block_start = 1'b1; @(negedge clk); block_start = 1'b0;
    chk("R4 done low after block_start", int'(done_irq), 0);
    e0 = edge_n;
    repeat (3) send_byte(8'hFF);
    chk("R4 done low during block", int'(done_irq), 0);
    tx_data = 8'h00; tx_valid = 1'b1;
    wait_cyc(400);
    chk("R3 gap spacing", edge_cyc[(e0+1)%64] - edge_cyc[e0%64], (10 + 3) * 16);
    chk("R3 gap spacing", edge_cyc[(e0+2)%64] - edge_cyc[(e0+1)%64], (10 + 3) * 16);
    chk("R4 no fourth character", edge_n - e0, 3);
    chk("R4 done after last frame", int'(done_irq), 1);
    tx_valid = 1'b0;
    block_start = 1'b1; @(negedge clk); block_start = 1'b0;
    chk("R4 done cleared by block_start", int'(done_irq), 0);
    block_mode = 1'b0; gap_bits = 8'd0; done_irq_en = 1'b0;

    // R9 rts threshold
    flow_sel = 2'd1;
    do_reset();
    for (int i = 0; i < 5; i++) begin
      send_byte(8'(i + 1));
      wait_count(i + 1);
    end
    chk("R9 rts high at 5", int'(rts_out), 1);
    send_byte(8'h06);
    wait_count(6);
    chk("R9 rts low at 6", int'(rts_out), 0);
    pop_one();
    chk("R9 rts high after pop", int'(rts_out), 1);

    // R9 cts holds transmission
    do_reset();
    cts_in = 1'b0;
    e0 = edge_n;
    tx_data = 8'h6B; tx_valid = 1'b1;
    wait_cyc(400);
    chk("R9 held by cts", edge_n - e0, 0);
    cts_in = 1'b1;
    release_pending(e0);
    wait_count(1);
    chk("R9 sent after cts", int'(rx_data), 8'h6B);
    flow_sel = 2'd0;

    // R10 software handshake
    flow_sel = 2'd2; loop_en = 1'b0;
    do_reset();
    drive_rx(8'h13, 1'b1, -1);
    wait_cyc(20);
    chk("R10 pause byte consumed", int'(rx_count), 0);
    e0 = edge_n;
    tx_data = 8'h55; tx_valid = 1'b1;
    wait_cyc(400);
    chk("R10 paused", edge_n - e0, 0);
    drive_rx(8'h11, 1'b1, -1);
    release_pending(e0);
    chk("R10 resumed", (edge_n > e0) ? 1 : 0, 1);
    wait_cyc(20);
    chk("R10 resume byte consumed", int'(rx_count), 0);
    flow_sel = 2'd0;

    // R7 framing error
    do_reset();
    f0 = fe_n;
    drive_rx(8'h5A, 1'b0, -1);
    chk("R7 frame_err pulse", fe_n - f0, 1);
    chk("R7 bad char dropped", int'(rx_count), 0);
    drive_rx(8'hA5, 1'b1, -1);
    wait_count(1);
    chk("R7 recovery byte", int'(rx_data), 8'hA5);
    chk("R7 single entry", int'(rx_count), 1);
    chk("R7 no second error", fe_n - f0, 1);

    // R6 glitch filter
    do_reset();
    f0 = fe_n;
    drv_rxd = 1'b0; wait_cyc(2); drv_rxd = 1'b1;
    wait_cyc(300);
    chk("R6 idle spike ignored", int'(rx_count), 0);
    chk("R6 idle spike no error", fe_n - f0, 0);
    drive_rx(8'h3C, 1'b1, 2);
    drive_rx(8'h3C, 1'b1, 6);
    wait_count(2);
    chk("R6 spike in one bit", int'(rx_data), 8'h3C);
    pop_one();
    chk("R6 spike in zero bit", int'(rx_data), 8'h3C);

    // R8 / R11 full queue and interrupt
    do_reset();
    rx_irq_en = 1'b1;
    for (int i = 0; i < 10; i++) drive_rx(8'(i * 7 + 3), 1'b1, -1);
    wait_cyc(10);
    chk("R8 count saturates", int'(rx_count), 8);
    chk("R11 irq with data", int'(rx_irq), 1);
    rx_irq_en = 1'b0; #1;
    chk("R11 irq masked", int'(rx_irq), 0);
    rx_irq_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk("R8 order", int'(rx_data), (i * 7 + 3) & 255);
      pop_one();
    end
    chk("R8 empty after drain", int'(rx_empty), 1);
    chk("R11 irq after drain", int'(rx_irq), 0);
    rx_irq_en = 1'b0;

    // R5 receive at divisor 1 with bench-driven line
    baud_div = 16'd1;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      drive_rx(8'(i * 17 + 1), 1'b1, -1);
      wait_count(1);
      chk("R5 receive div 1", int'(rx_data), (i * 17 + 1) & 255);
      pop_one();
    end

    summary();
    $finish;
  end
endmodule